// File: doc/BRIEF.md
# Interval Countdown Timer with Interrupt

This block is a general-purpose 32-bit countdown timer. Software sees the count as two 16-bit halves. A command register starts and stops it. While the timer runs, it decrements once for each pulse on a tick-enable input. A system-clock prescaler outside the block produces that pulse at the nominal 5 MHz rate. When the count passes zero it reloads to all ones and keeps running. At the same moment it raises a timer-complete flag in an interrupt status register.

The status register is write-one-to-clear. A mask register selects which status bits drive the single level-sensitive interrupt line. Reading the low half of the count captures the high half at that same instant. A following read of the high half therefore returns a value that matches the low half, even if the counter has moved on in between.

Register map (`addr`): 0 command, 1 interrupt status, 2 interrupt mask, 3 count low half, 4 count high half. Any other address reads as zero and ignores writes.

Top module: `tmr_top`

## Requirements
- R1: While running, each cycle with `tickEn` high decrements the 32-bit count {high half, low half} by one, and a borrow out of the low half propagates into the high half.
- R2: A command write with bit 5 (start) set and bit 4 (stop) clear starts the timer. A command write with bit 4 set stops it and freezes the count, and stop wins if both bits are set. Command reads return bit 5 = running and bit 4 = stopped.
- R3: A tick taken while the count is zero reloads the count to 0xFFFFFFFF, counting continues, and status bit 7 (timer complete) is set.
- R4: After reset the timer is stopped, the command register reads 0x0010, and the count, status and mask read zero.
- R5: A write to either count half replaces that half in the cycle of the write and takes priority over a tick in the same cycle. Later ticks count down from the written value.
- R6: `irq` is high exactly when the bitwise AND of the mask and status registers is non-zero.
- R7: Bit 15 of the mask register is never stored and always reads zero.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A reload in the same cycle as a clear keeps bit 7 set.
- R9: A read of the low half (`rdEn` high, address 3) captures the high half. A read of the high half returns that captured value, not the live one.
- R10: While `tickEn` is low the count does not change, even when the timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count pulse from the prescaler |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (captures the high half on a low-half read) |
| addr | input | 3 | Register select |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches these rules on every cycle: decrement on a tick, reload to all ones with the completion flag on a zero tick, the frozen count while stopped or without a tick, the start and stop transitions, the dropped mask bit, write-one-to-clear, and a low interrupt line when status is empty. The bench scenarios cover what needs a sequence of operations: the borrow across halves as seen through the ports, write priority over a simultaneous tick, the exact reset readback, and a coherent two-part read while the counter changes between the reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int HALF_W    = 16;
  localparam int NUM_HALF  = 2;
  localparam int CNT_W     = HALF_W * NUM_HALF;
  localparam int ADDR_W    = 3;
  localparam int START_BIT = 5;
  localparam int STOP_BIT  = 4;
  localparam int DONE_BIT  = 7;
  localparam int MASK_DROP = 15;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD    = 3'd0,
    REG_STAT   = 3'd1,
    REG_MASK   = 3'd2,
    REG_CNT_LO = 3'd3,
    REG_CNT_HI = 3'd4
  } tmrReg_e;

  typedef struct packed {
    logic [NUM_HALF-1:0] loadVec;
    logic                countEn;
    logic                latchHi;
    logic [HALF_W-1:0]   data;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  count,
  output logic [HALF_W-1:0] hiShadow,
  output logic              wrapPulse
);
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] loadMerge;

  // Merge each half that is being written into the current count.
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign loadMerge[h*HALF_W +: HALF_W] =
      strb.loadVec[h] ? strb.data : count[h*HALF_W +: HALF_W];
  end

  assign wrapPulse = strb.countEn && !(|strb.loadVec) && (count == '0);

  always_comb begin
    nextCount = count;
    if (|strb.loadVec) begin
      nextCount = loadMerge;
    end else if (strb.countEn) begin
      nextCount = (count == '0) ? '1 : count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      hiShadow <= '0;
    end else begin
      count <= nextCount;
      if (strb.latchHi) hiShadow <= count[CNT_W-1 -: HALF_W];
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [HALF_W-1:0] countLo,
  input  logic [HALF_W-1:0] hiShadow,
  input  logic              wrapPulse,
  output tmrStrobe_t        strb,
  output logic              running,
  output logic [HALF_W-1:0] statReg,
  output logic [HALF_W-1:0] maskReg,
  output logic [HALF_W-1:0] rdData,
  output logic              irq
);
  localparam logic [HALF_W-1:0] DROP_KEEP = ~(HALF_W'(1) << MASK_DROP);
  localparam logic [HALF_W-1:0] DONE_VEC  = HALF_W'(1) << DONE_BIT;

  logic selCmd, selStat, selMask, selLo, selHi;
  logic [HALF_W-1:0] clearVec;
  logic [HALF_W-1:0] cmdView;

  assign selCmd  = (addr == REG_CMD);
  assign selStat = (addr == REG_STAT);
  assign selMask = (addr == REG_MASK);
  assign selLo   = (addr == REG_CNT_LO);
  assign selHi   = (addr == REG_CNT_HI);

  assign strb.loadVec = {wrEn && selHi, wrEn && selLo};
  assign strb.countEn = running && tickEn;
  assign strb.latchHi = rdEn && selLo;
  assign strb.data    = wrData;

  assign clearVec = (wrEn && selStat) ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      statReg <= '0;
      maskReg <= '0;
    end else begin
      if (wrEn && selCmd) begin
        if (wrData[STOP_BIT])       running <= 1'b0;
        else if (wrData[START_BIT]) running <= 1'b1;
      end
      statReg <= (statReg & ~clearVec) | (wrapPulse ? DONE_VEC : '0);
      if (wrEn && selMask) maskReg <= wrData & DROP_KEEP;
    end
  end

  always_comb begin
    cmdView = '0;
    cmdView[START_BIT] = running;
    cmdView[STOP_BIT]  = !running;
  end

  always_comb begin
    rdData = '0;
    if (selCmd)  rdData = cmdView;
    if (selStat) rdData = statReg;
    if (selMask) rdData = maskReg;
    if (selLo)   rdData = countLo;
    if (selHi)   rdData = hiShadow;
  end

  assign irq = |(maskReg & statReg);
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              irq
);
  tmrStrobe_t        strb;
  logic [CNT_W-1:0]  countVal;
  logic [HALF_W-1:0] hiShadow;
  logic              wrapPulse;
  logic              running;
  logic [HALF_W-1:0] statReg;
  logic [HALF_W-1:0] maskReg;

  tmr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .countLo   (countVal[HALF_W-1:0]),
    .hiShadow  (hiShadow),
    .wrapPulse (wrapPulse),
    .strb      (strb),
    .running   (running),
    .statReg   (statReg),
    .maskReg   (maskReg),
    .rdData    (rdData),
    .irq       (irq)
  );

  tmr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .count     (countVal),
    .hiShadow  (hiShadow),
    .wrapPulse (wrapPulse)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [HALF_W-1:0] wrData,
  input logic [CNT_W-1:0]  countVal,
  input logic              running,
  input logic [HALF_W-1:0] statReg,
  input logic [HALF_W-1:0] maskReg,
  input logic              irq
);
  logic cntWr;
  assign cntWr = wrEn && (addr == REG_CNT_LO || addr == REG_CNT_HI);

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    running && tickEn && !cntWr && countVal != '0 |=> countVal == $past(countVal) - CNT_W'(1)); // R1

  AST_START: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == REG_CMD && wrData[START_BIT] && !wrData[STOP_BIT] |=> running); // R2

  AST_STOP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == REG_CMD && wrData[STOP_BIT] |=> !running); // R2

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    running && tickEn && !cntWr && countVal == '0 |=> countVal == '1 && statReg[DONE_BIT]); // R3

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!running || !tickEn) && !cntWr |=> $stable(countVal)); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    statReg == '0 |-> !irq); // R6

  AST_MASK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !maskReg[MASK_DROP]); // R7

  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == REG_STAT && wrData[DONE_BIT] && !(running && tickEn && !cntWr && countVal == '0)
    |=> !statReg[DONE_BIT]); // R8
endmodule

bind tmr_top tmr_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .countVal (countVal),
  .running  (running),
  .statReg  (statReg),
  .maskReg  (maskReg),
  .irq      (irq)
);

// File: tb/tmr_top_bench.sv
module tmr_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_top u_tmr_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readCount(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(3'd3, lo);
    rd(3'd4, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic loadCount(input logic [31:0] v);
    wr(3'd4, v[31:16]);
    wr(3'd3, v[15:0]);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    logic [31:0] c;
    rd(3'd0, d); check("R4 command after reset", d, 32'h0010);
    rd(3'd1, d); check("R4 status after reset", d, 0);
    rd(3'd2, d); check("R4 mask after reset", d, 0);
    readCount(c); check("R4 count after reset", c, 0);
    check("R4 irq after reset", irq, 0);
  endtask

  task automatic t_stopped;
    logic [31:0] c;
    loadCount(32'h0001_0005);
    ticks(3);
    readCount(c); check("R2 stopped timer ignores ticks", c, 32'h0001_0005);
  endtask

  task automatic t_count;
    logic [31:0] c;
    logic [15:0] d;
    wr(3'd0, 16'h0020);
    rd(3'd0, d); check("R2 command reads running", d, 32'h0020);
    ticks(3);
    readCount(c); check("R1 three ticks", c, 32'h0001_0002);
    loadCount(32'h0001_0000);
    ticks(1);
    readCount(c); check("R1 borrow into high half", c, 32'h0000_FFFF);
    @(negedge clk); tickEn = 1'b0;
    repeat (5) @(negedge clk);
    readCount(c); check("R10 no tick no change", c, 32'h0000_FFFF);
  endtask

  task automatic t_stop;
    logic [31:0] c;
    logic [15:0] d;
    wr(3'd0, 16'h0030);
    rd(3'd0, d); check("R2 stop wins over start", d, 32'h0010);
    ticks(4);
    readCount(c); check("R2 stop freezes count", c, 32'h0000_FFFF);
  endtask

  task automatic t_underflow;
    logic [31:0] c;
    logic [15:0] d;
    loadCount(32'h0000_0001);
    wr(3'd0, 16'h0020);
    check("R6 irq low before flag", irq, 0);
    ticks(2);
    readCount(c); check("R3 reload to all ones", c, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R3 completion flag", d, 32'h0080);
    check("R6 irq low with mask clear", irq, 0);
    ticks(1);
    readCount(c); check("R3 keeps counting after reload", c, 32'hFFFF_FFFE);
  endtask

  task automatic t_irq_mask;
    logic [15:0] d;
    wr(3'd2, 16'h0080);
    #1 check("R6 irq high when masked flag set", irq, 1);
    wr(3'd2, 16'hFF7F);
    #1 check("R6 irq low when flag bit unmasked", irq, 0);
    wr(3'd2, 16'hFFFF);
    rd(3'd2, d); check("R7 mask bit 15 dropped", d, 32'h7FFF);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    wr(3'd0, 16'h0010);
    wr(3'd1, 16'h0000);
    rd(3'd1, d); check("R8 writing zero keeps flag", d, 32'h0080);
    wr(3'd1, 16'hFF7F);
    rd(3'd1, d); check("R8 other ones keep flag", d, 32'h0080);
    wr(3'd1, 16'h0080);
    rd(3'd1, d); check("R8 writing one clears flag", d, 0);
    check("R6 irq drops after clear", irq, 0);
  endtask

  task automatic t_write_priority;
    logic [31:0] c;
    loadCount(32'h0000_0100);
    wr(3'd0, 16'h0020);
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; addr = 3'd3; wrData = 16'h0050;
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'd0; tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    readCount(c); check("R5 write beats tick then counts", c, 32'h0000_004F);
  endtask

  task automatic t_coherent;
    logic [15:0] lo, hi;
    wr(3'd0, 16'h0010);
    loadCount(32'h0002_0000);
    wr(3'd0, 16'h0020);
    rd(3'd3, lo);
    ticks(1);
    rd(3'd4, hi);
    check("R9 low half read", lo, 32'h0000);
    check("R9 high half is captured value", hi, 32'h0002);
    rd(3'd3, lo);
    rd(3'd4, hi);
    check("R9 fresh pair after tick", {hi, lo}, 32'h0001_FFFF);
    wr(3'd0, 16'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_stopped();
    t_count();
    t_stop();
    t_underflow();
    t_irq_mask();
    t_w1c();
    t_write_priority();
    t_coherent();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule